// File: doc/BRIEF.md
# Wheel-Spin Brake Pulsing Controller

This block watches a wheel-rotation signal and decides, once per sampling interval, whether a brake output should be held on or pulsed. Every 0-to-1 transition of the rotation input counts as one spin. An external interval tick, nominally every 100 ms, closes each sampling window. At that tick, a wheel that turned at least a threshold number of times is taken as rolling freely, and the brake is driven on. A wheel that turned fewer times is taken as locked, and the brake output is inverted from its previous value, so a locked wheel sees the brake alternate between on and off from one interval to the next.

The spin counter restarts at every tick. Its live value is brought out so that a display can show the current count. The rotation input must already be debounced and synchronised to the clock. The interval tick is a one-cycle pulse made by a timer outside this block. The threshold (default 5) and the counter width (default 4 bits) are parameters.

Top module: `spin_brake_ctrl`

## Requirements
- R1: After reset (`rst_n` low, active-low), `brake_o` is 0 and `spin_count_o` is 0.
- R2: A spin is counted only on a 0-to-1 transition of `spin_i`. Holding `spin_i` high adds nothing further. A level that is already high when reset is released is not counted.
- R3: On a cycle with `tick_i` high and a pre-tick count below THRESH (default 5), `brake_o` takes the inverse of its previous value.
- R4: On a cycle with `tick_i` high and a pre-tick count of THRESH or more, `brake_o` becomes 1, including when it was already 1.
- R5: On a cycle with `tick_i` high and no rising edge, `spin_count_o` becomes 0 at that clock edge.
- R6: A rising edge in the same cycle as a tick is counted into the new interval, so `spin_count_o` becomes 1. The brake decision for that tick uses the count from before that edge.
- R7: `spin_count_o` saturates at 2**CNT_W-1 (15 by default) and does not wrap.
- R8: `brake_o` changes only at clock edges where `tick_i` is high.
- R9: `spin_count_o` shows the new value from the clock edge that samples a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spin_i | input | 1 | Synchronised wheel-rotation level |
| tick_i | input | 1 | One-cycle pulse that ends the sampling interval |
| brake_o | output | 1 | Brake drive, 1 = applied |
| spin_count_o | output | CNT_W | Spins counted so far in the current interval |

## Verification
There is exactly one register between each input and its result. A rising edge of `spin_i` shows up in `spin_count_o` at the first clock edge that samples it. A tick updates `brake_o` and clears or reloads the count at the clock edge that samples it. The bench changes inputs only on falling clock edges and reads the outputs on the next falling edge, half a period after the edge that updated them. Checks of stability, for a held level or the brake between ticks, are repeated over several of these sampling points.

// File: rtl/spin_brake_pkg.sv
package spin_brake_pkg;

    // Brake action selected at an interval boundary
    typedef enum logic [1:0] {
        BRK_HOLD   = 2'd0,
        BRK_TOGGLE = 2'd1,
        BRK_FORCE  = 2'd2
    } brake_act_e;

endpackage

// File: rtl/spin_rise_det.sv
module spin_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);

    typedef struct packed {
        logic prev;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_i;
    end

    // Reset to 1 so that a level already high at reset release is not an edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: 1'b1};
        else        st_q <= st_d;
    end

    assign rise_o = level_i & ~st_q.prev;

endmodule

// File: rtl/spin_counter.sv
module spin_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            // new interval starts; a coincident edge belongs to it
            st_d.cnt = rise_i ? CNT_ONE : '0;
        end else if (rise_i && st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0};
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;

    // R5
    tick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !rise_i) |=> (count_o == '0));

    // R6
    tick_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && rise_i) |=> (count_o == CNT_ONE));

    // R7
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && count_o == CNT_MAX) |=> (count_o == CNT_MAX));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !rise_i) |=> $stable(count_o));

endmodule

// File: rtl/brake_decider.sv
module brake_decider #(
    parameter int CNT_W  = 4,
    parameter int THRESH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             brake_o
);
    import spin_brake_pkg::*;

    localparam logic [CNT_W-1:0] THR = CNT_W'(THRESH);

    typedef struct packed {
        logic brake;
    } bd_state_t;

    bd_state_t  st_d, st_q;
    brake_act_e act;

    always_comb begin
        if (!tick_i)            act = BRK_HOLD;
        else if (count_i >= THR) act = BRK_FORCE;
        else                    act = BRK_TOGGLE;
    end

    always_comb begin
        st_d = st_q;
        case (act)
            BRK_FORCE:  st_d.brake = 1'b1;
            BRK_TOGGLE: st_d.brake = ~st_q.brake;
            default:    st_d.brake = st_q.brake;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{brake: 1'b0};
        else        st_q <= st_d;
    end

    assign brake_o = st_q.brake;

    // R3
    pulse_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && count_i < THR) |=> (brake_o != $past(brake_o)));

    // R4
    force_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && count_i >= THR) |=> brake_o);

    // R8
    brake_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(brake_o));

endmodule

// File: rtl/spin_brake_ctrl.sv
module spin_brake_ctrl #(
    parameter int CNT_W  = 4,
    parameter int THRESH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spin_i,
    input  logic             tick_i,
    output logic             brake_o,
    output logic [CNT_W-1:0] spin_count_o
);

    logic rise;

    spin_rise_det u_rise (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (spin_i),
        .rise_o  (rise)
    );

    spin_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise),
        .tick_i  (tick_i),
        .count_o (spin_count_o)
    );

    brake_decider #(.CNT_W(CNT_W), .THRESH(THRESH)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .count_i (spin_count_o),
        .brake_o (brake_o)
    );

endmodule

// File: tb/spin_brake_ctrl_bench.sv
module spin_brake_ctrl_bench;

    localparam int CNT_W  = 4;
    localparam int THRESH = 5;
    localparam int MAXC   = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             spin_i = 1'b0;
    logic             tick_i = 1'b0;
    logic             brake_o;
    logic [CNT_W-1:0] spin_count_o;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_brake = 0;
    int exp_cnt   = 0;

    always #5 clk = ~clk;

    spin_brake_ctrl #(.CNT_W(CNT_W), .THRESH(THRESH)) u_spin_brake_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .spin_i       (spin_i),
        .tick_i       (tick_i),
        .brake_o      (brake_o),
        .spin_count_o (spin_count_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one rising edge: high for one cycle, then low for one cycle
    task automatic pulse();
        @(negedge clk) spin_i = 1'b1;
        @(negedge clk) spin_i = 1'b0;
        if (exp_cnt < MAXC) exp_cnt++;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) pulse();
    endtask

    // tick with no edge; updates the model and checks results
    task automatic tick(input string req);
        @(negedge clk) tick_i = 1'b1;
        exp_brake = (exp_cnt >= THRESH) ? 1 : 1 - exp_brake;
        exp_cnt   = 0;
        @(negedge clk) tick_i = 1'b0;
        chk(req, int'(brake_o), exp_brake);
        chk("R5 count cleared", int'(spin_count_o), 0);
    endtask

    task automatic t_reset();
        rst_n  = 1'b0;
        spin_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 brake in reset", int'(brake_o), 0);
        chk("R1 count in reset", int'(spin_count_o), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 high at reset release not counted", int'(spin_count_o), 0);
        spin_i = 1'b0;
        exp_brake = 0;
        exp_cnt   = 0;
        @(negedge clk);
        pulse();
        chk("R9 count after one edge", int'(spin_count_o), 1);
    endtask

    task automatic t_level_hold();
        @(negedge clk) spin_i = 1'b1;
        @(negedge clk);
        chk("R9 count due one edge after rise", int'(spin_count_o), exp_cnt + 1);
        repeat (5) @(negedge clk);
        chk("R2 held level counted once", int'(spin_count_o), exp_cnt + 1);
        spin_i = 1'b0;
        exp_cnt++;
        @(negedge clk);
    endtask

    task automatic t_slow_wheel();
        // currently 2 spins, below threshold
        chk("R2 two spins", int'(spin_count_o), 2);
        tick("R3 toggle with 2 spins");
        repeat (6) @(negedge clk);
        chk("R8 brake steady between ticks", int'(brake_o), exp_brake);
        tick("R3 toggle with 0 spins");
        pulses(THRESH - 1);
        tick("R3 toggle at threshold-1");
    endtask

    task automatic t_fast_wheel();
        pulses(THRESH);
        tick("R4 forced on at threshold");
        pulses(THRESH + 1);
        tick("R4 stays on above threshold");
        chk("R4 brake is 1", int'(brake_o), 1);
        pulses(1);
        tick("R3 toggle off after slow interval");
        chk("R3 brake is 0", int'(brake_o), 0);
    endtask

    task automatic t_coincide();
        pulses(THRESH - 1);
        @(negedge clk) begin
            spin_i = 1'b1;
            tick_i = 1'b1;
        end
        exp_brake = 1 - exp_brake;
        @(negedge clk) begin
            spin_i = 1'b0;
            tick_i = 1'b0;
        end
        chk("R6 coincident edge starts new interval", int'(spin_count_o), 1);
        chk("R6 decision uses pre-edge count", int'(brake_o), exp_brake);
        exp_cnt = 1;
        @(negedge clk);
        chk("R6 count holds after coincident tick", int'(spin_count_o), 1);
    endtask

    task automatic t_saturate();
        tick("R3 clear before saturation");
        pulses(MAXC + 5);
        chk("R7 saturated count", int'(spin_count_o), MAXC);
        tick("R4 forced on after saturation");
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        pulses(1);
        chk("R2 second edge", int'(spin_count_o), 2);
        t_level_hold();
        tick("R3 toggle with 3 spins");
        pulses(2);
        t_slow_wheel();
        t_fast_wheel();
        t_coincide();
        t_saturate();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule